// File: doc/BRIEF.md
# Page Protection and Fault Classifier

This block takes one memory access per request and decides whether it may proceed. When it may not, the block names the fault to raise. The request carries several things: the access kind, the privilege state, the two translation-enable bits and the segment's key and no-execute bits. It also carries the two-bit page protection field, the result class of a table lookup done elsewhere and the effective address. The block selects an access key from the privilege state and looks up rights in a two-level key/protection table. It then checks the right that the access kind needs and encodes any failure into a fault kind and a 32-bit syndrome. The syndrome value depends on the failure class, and for data accesses also on read versus write.

Two bypass paths produce an address without a table entry. With translation off, the effective address passes through unchanged. A direct-store segment with the forced-I/O bus unit ID is remapped into a fixed window. All results are registered and appear one cycle after the request strobe. A data fault also captures the faulting address, and that address is held until the next data fault.

Top module: `prot_fault_unit`

## Requirements
- R1: When `req_valid` is high at a clock edge, `rsp_valid` is high for exactly the following cycle and all response fields reflect that request. With no request, `rsp_valid` stays low and the other outputs hold their values.
- R2: Translation is off when `xlat_insn_en` is 0 for a fetch, or when `xlat_data_en` is 0 for a data access. In that case the access is allowed, `rsp_perm` = 3'b111, `rsp_bypass` = 1 and `rsp_phys_addr` equals `req_addr`. The translation bit of the other kind has no effect.
- R3: With translation on, `req_lookup` = 2 marks a direct-store segment. If `req_bus_id` equals 9'h07F, the access is allowed for every kind with all rights, and `rsp_phys_addr` = {`req_seg_low`, `req_addr[27:0]`}.
- R4: The access key is `req_key_user` when `req_user` = 1, and `req_key_sup` when `req_user` = 0.
- R5: For a found entry (`req_lookup` = 1), read and write rights come from the key and `req_pp`. With key 0, PP values 0, 1 and 2 give read+write and PP 3 gives read only. With key 1, PP 0 gives neither, PP 1 and PP 3 give read only, and PP 2 gives read+write. `rsp_perm` bits are {read, write, execute}.
- R6: Execute right is present only when `req_nx` = 0. A fetch with `req_nx` = 1 that is not a direct-store access raises an instruction fault with syndrome 32'h1000_0000 and `rsp_perm` = 0. The execute right does not depend on PP.
- R7: When a found entry lacks the needed right, a data access raises a data fault. The syndrome is 32'h0A00_0000 for a write and 32'h0800_0000 for a read.
- R8: With translation on and `req_lookup` of 0 or 3 (miss), a fetch raises an instruction fault with syndrome 32'h4000_0000. A data read gets a data fault with 32'h4000_0000, and a data write gets a data fault with 32'h4200_0000.
- R9: A fetch from a direct-store segment whose bus ID is not 9'h07F raises an instruction fault with syndrome 32'h1000_0000.
- R10: A data access to such a non-forced direct-store segment is checked by key only. A read needs key 0 and a write needs key 1. `rsp_perm` is 3'b100 for key 0 and 3'b010 for key 1. On success `rsp_phys_addr` equals `req_addr` with `rsp_bypass` = 1. On failure the codes of R7 apply.
- R11: `rsp_fault_addr` is loaded with `req_addr` only on a data fault. It holds its value through instruction faults and allowed accesses.
- R12: Fault kind encoding is 0 none, 1 instruction, 2 data. Access kinds are 0 read, 1 write, 2 fetch, and 3 acts as read. `rsp_allow` is 1 exactly when the fault kind is 0, and the syndrome is zero exactly then. An instruction fault occurs only for a fetch. `rsp_bypass` is 0 on the found-entry path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| xlat_insn_en | input | 1 | Instruction translation enable |
| xlat_data_en | input | 1 | Data translation enable |
| req_key_sup | input | 1 | Segment key used in supervisor mode |
| req_key_user | input | 1 | Segment key used in user mode |
| req_nx | input | 1 | Segment no-execute |
| req_pp | input | 2 | Page protection field of the found entry |
| req_lookup | input | 2 | Lookup class: 0 miss, 1 entry found, 2 direct-store, 3 miss |
| req_bus_id | input | 9 | Direct-store bus unit ID |
| req_seg_low | input | 4 | Low segment bits used by the forced-I/O window |
| req_addr | input | 32 | Effective address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_perm | output | 3 | Rights {read, write, execute} |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 2 | Fault kind |
| rsp_code | output | 32 | Syndrome code |
| rsp_fault_addr | output | 32 | Captured address of the last data fault |
| rsp_bypass | output | 1 | Address produced by a bypass path |
| rsp_phys_addr | output | 32 | Bypass address (zero when not bypassed) |

## Verification
The hardest cases to reach are those where two classification rules meet and the order between them decides the result. One is a forced-I/O fetch from a segment marked no-execute, which must still be allowed. Another is a fetch from a no-execute segment that also misses, which must report the no-execute code and not the miss code. A third is a key-1, PP-0 fetch, which has no read right yet must still execute. The bench sets each of these conflicts on purpose with single directed requests. It also places instruction faults and allowed accesses between data faults, so that any stray update of the captured address shows up at the port.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        LK_MISS   = 2'd0,
        LK_ENTRY  = 2'd1,
        LK_DIRECT = 2'd2,
        LK_NONE   = 2'd3
    } lookup_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_INSN = 2'd1,
        FLT_DATA = 2'd2,
        FLT_RSVD = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        FAIL_NONE   = 2'd0,
        FAIL_NOEXEC = 2'd1,
        FAIL_PROT   = 2'd2,
        FAIL_MISS   = 2'd3
    } fail_e;

    typedef enum logic [1:0] {
        PHYS_NONE   = 2'd0,
        PHYS_EFF    = 2'd1,
        PHYS_FORCED = 2'd2,
        PHYS_RSVD   = 2'd3
    } phys_sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        perm_t     perm;
        logic      allow;
        fault_e    fault;
        logic [31:0] code;
        logic      capture;
        phys_sel_e phys;
    } verdict_t;

    localparam logic [31:0] SYN_NOEXEC  = 32'h1000_0000;
    localparam logic [31:0] SYN_PROT_RD = 32'h0800_0000;
    localparam logic [31:0] SYN_PROT_WR = 32'h0A00_0000;
    localparam logic [31:0] SYN_MISS_RD = 32'h4000_0000;
    localparam logic [31:0] SYN_MISS_WR = 32'h4200_0000;

    localparam perm_t PERM_ALL  = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
    localparam perm_t PERM_NONE = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};

    // Two-level key / protection-field table; execute follows the segment only.
    function automatic perm_t pp_rights(input logic key, input logic [1:0] pp,
                                        input logic nx);
        perm_t p;
        p.ex = ~nx;
        if (!key) begin
            p.rd = 1'b1;
            p.wr = (pp != 2'd3);
        end else begin
            p.rd = (pp != 2'd0);
            p.wr = (pp == 2'd2);
        end
        return p;
    endfunction

    function automatic logic has_right(input perm_t p, input acc_kind_e k);
        logic r;
        case (k)
            ACC_FETCH: r = p.ex;
            ACC_WRITE: r = p.wr;
            default:   r = p.rd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prot_rights.sv
module prot_rights
    import prot_pkg::*;
(
    input  logic        user_mode,
    input  logic        key_sup,
    input  logic        key_user,
    input  logic [1:0]  pp,
    input  logic        nx,
    output logic        key,
    output perm_t       perm
);

    always_comb begin
        key  = user_mode ? key_user : key_sup;
        perm = pp_rights(key, pp, nx);
    end

endmodule

// File: rtl/prot_syndrome.sv
module prot_syndrome
    import prot_pkg::*;
(
    input  fail_e       fail,
    input  acc_kind_e   kind,
    output fault_e      fault,
    output logic [31:0] code,
    output logic        capture
);

    logic is_fetch;
    logic is_write;

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        is_write = (kind == ACC_WRITE);

        if (fail == FAIL_NONE)
            fault = FLT_NONE;
        else if (is_fetch)
            fault = FLT_INSN;
        else
            fault = FLT_DATA;

        case (fail)
            FAIL_NOEXEC: code = SYN_NOEXEC;
            FAIL_PROT:   code = is_write ? SYN_PROT_WR : SYN_PROT_RD;
            FAIL_MISS:   code = is_write ? SYN_MISS_WR : SYN_MISS_RD;
            default:     code = 32'h0;
        endcase

        capture = (fault == FLT_DATA);
    end

endmodule

// File: rtl/prot_classify.sv
module prot_classify
    import prot_pkg::*;
#(
    parameter int                   BUSID_W   = 9,
    parameter logic [BUSID_W-1:0]   FORCED_ID = 9'h07F
)(
    input  acc_kind_e           kind,
    input  logic                insn_en,
    input  logic                data_en,
    input  lookup_e             lookup,
    input  logic                nx,
    input  logic [BUSID_W-1:0]  bus_id,
    input  logic                key,
    input  perm_t               entry_perm,
    output verdict_t            verdict
);

    logic      is_fetch;
    logic      xlat_on;
    perm_t     ds_perm;
    perm_t     perm;
    fail_e     fail;
    phys_sel_e phys;
    fault_e    fault;
    logic [31:0] code;
    logic      capture;

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        xlat_on  = is_fetch ? insn_en : data_en;
        ds_perm  = key ? '{rd: 1'b0, wr: 1'b1, ex: 1'b0}
                       : '{rd: 1'b1, wr: 1'b0, ex: 1'b0};

        fail = FAIL_NONE;
        perm = PERM_NONE;
        phys = PHYS_NONE;

        if (!xlat_on) begin
            perm = PERM_ALL;
            phys = PHYS_EFF;
        end else if (lookup == LK_DIRECT) begin
            if (bus_id == FORCED_ID) begin
                perm = PERM_ALL;
                phys = PHYS_FORCED;
            end else if (is_fetch) begin
                fail = FAIL_NOEXEC;
            end else begin
                perm = ds_perm;
                if (has_right(ds_perm, kind))
                    phys = PHYS_EFF;
                else
                    fail = FAIL_PROT;
            end
        end else if (is_fetch && nx) begin
            fail = FAIL_NOEXEC;
        end else if (lookup == LK_ENTRY) begin
            perm = entry_perm;
            if (!has_right(entry_perm, kind))
                fail = FAIL_PROT;
        end else begin
            fail = FAIL_MISS;
        end
    end

    prot_syndrome u_syndrome (
        .fail    (fail),
        .kind    (kind),
        .fault   (fault),
        .code    (code),
        .capture (capture)
    );

    always_comb begin
        verdict.perm    = perm;
        verdict.allow   = (fail == FAIL_NONE);
        verdict.fault   = fault;
        verdict.code    = code;
        verdict.capture = capture;
        verdict.phys    = phys;
    end

endmodule

// File: rtl/prot_fault_unit.sv
module prot_fault_unit
    import prot_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter int                 SEGSEL_W  = 4,
    parameter int                 BUSID_W   = 9,
    parameter logic [BUSID_W-1:0] FORCED_ID = 9'h07F
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_user,
    input  logic                 xlat_insn_en,
    input  logic                 xlat_data_en,
    input  logic                 req_key_sup,
    input  logic                 req_key_user,
    input  logic                 req_nx,
    input  logic [1:0]           req_pp,
    input  logic [1:0]           req_lookup,
    input  logic [BUSID_W-1:0]   req_bus_id,
    input  logic [SEGSEL_W-1:0]  req_seg_low,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_perm,
    output logic                 rsp_allow,
    output logic [1:0]           rsp_fault,
    output logic [31:0]          rsp_code,
    output logic [ADDR_W-1:0]    rsp_fault_addr,
    output logic                 rsp_bypass,
    output logic [ADDR_W-1:0]    rsp_phys_addr
);

    localparam int OFFS_W = ADDR_W - SEGSEL_W;

    logic              key;
    perm_t             entry_perm;
    verdict_t          verdict;
    logic [ADDR_W-1:0] phys_next;

    prot_rights u_rights (
        .user_mode (req_user),
        .key_sup   (req_key_sup),
        .key_user  (req_key_user),
        .pp        (req_pp),
        .nx        (req_nx),
        .key       (key),
        .perm      (entry_perm)
    );

    prot_classify #(
        .BUSID_W   (BUSID_W),
        .FORCED_ID (FORCED_ID)
    ) u_classify (
        .kind       (acc_kind_e'(req_kind)),
        .insn_en    (xlat_insn_en),
        .data_en    (xlat_data_en),
        .lookup     (lookup_e'(req_lookup)),
        .nx         (req_nx),
        .bus_id     (req_bus_id),
        .key        (key),
        .entry_perm (entry_perm),
        .verdict    (verdict)
    );

    always_comb begin
        case (verdict.phys)
            PHYS_EFF:    phys_next = req_addr;
            PHYS_FORCED: phys_next = {req_seg_low, req_addr[OFFS_W-1:0]};
            default:     phys_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_perm       <= '0;
            rsp_allow      <= 1'b0;
            rsp_fault      <= '0;
            rsp_code       <= '0;
            rsp_fault_addr <= '0;
            rsp_bypass     <= 1'b0;
            rsp_phys_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_perm      <= verdict.perm;
                rsp_allow     <= verdict.allow;
                rsp_fault     <= verdict.fault;
                rsp_code      <= verdict.code;
                rsp_bypass    <= (verdict.phys != PHYS_NONE);
                rsp_phys_addr <= phys_next;
                if (verdict.capture)
                    rsp_fault_addr <= req_addr;
            end
        end
    end

endmodule

// File: rtl/prot_fault_unit_chk.sv
module prot_fault_unit_chk #(
    parameter int ADDR_W   = 32,
    parameter int SEGSEL_W = 4,
    parameter int BUSID_W  = 9
)(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic                req_user,
    input logic                xlat_insn_en,
    input logic                xlat_data_en,
    input logic                req_key_sup,
    input logic                req_key_user,
    input logic                req_nx,
    input logic [1:0]          req_pp,
    input logic [1:0]          req_lookup,
    input logic [BUSID_W-1:0]  req_bus_id,
    input logic [SEGSEL_W-1:0] req_seg_low,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                rsp_valid,
    input logic [2:0]          rsp_perm,
    input logic                rsp_allow,
    input logic [1:0]          rsp_fault,
    input logic [31:0]         rsp_code,
    input logic [ADDR_W-1:0]   rsp_fault_addr,
    input logic                rsp_bypass,
    input logic [ADDR_W-1:0]   rsp_phys_addr
);

    localparam int OFFS_W = ADDR_W - SEGSEL_W;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_real_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_kind == 2'd2) ? !xlat_insn_en : !xlat_data_en))
        |=> (rsp_allow && rsp_perm == 3'b111 && rsp_bypass
             && rsp_phys_addr == $past(req_addr)));

    assert_forced_io_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && xlat_insn_en && xlat_data_en && req_lookup == 2'd2
         && req_bus_id == 9'h07F)
        |=> (rsp_allow && rsp_phys_addr ==
             {$past(req_seg_low), $past(req_addr[OFFS_W-1:0])}));

    assert_no_exec_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_nx && xlat_insn_en && xlat_data_en && req_lookup != 2'd2)
        |=> !rsp_perm[0]);

    assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd2) |-> rsp_fault_addr == $past(req_addr));

    assert_hold_addr_R11: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_fault == 2'd2) |-> $stable(rsp_fault_addr));

    assert_consistent_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_allow == (rsp_fault == 2'd0))
                       && ((rsp_fault == 2'd0) == (rsp_code == 32'h0))));

    assert_insn_fetch_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd1) |-> $past(req_kind) == 2'd2);

endmodule

bind prot_fault_unit prot_fault_unit_chk #(
    .ADDR_W   (ADDR_W),
    .SEGSEL_W (SEGSEL_W),
    .BUSID_W  (BUSID_W)
) u_chk (.*);

// File: tb/test_prot_fault_unit.sv
`timescale 1ns/1ps
module test_prot_fault_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_user;
    logic        xlat_insn_en;
    logic        xlat_data_en;
    logic        req_key_sup;
    logic        req_key_user;
    logic        req_nx;
    logic [1:0]  req_pp;
    logic [1:0]  req_lookup;
    logic [8:0]  req_bus_id;
    logic [3:0]  req_seg_low;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic [2:0]  rsp_perm;
    logic        rsp_allow;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_code;
    logic [31:0] rsp_fault_addr;
    logic        rsp_bypass;
    logic [31:0] rsp_phys_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    prot_fault_unit i_prot_fault_unit (.*);

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // One request: translation on for both kinds unless overridden.
    task automatic issue(input logic [1:0] k, input logic usr, input logic ien,
                         input logic den, input logic ks, input logic kp,
                         input logic nx, input logic [1:0] pp,
                         input logic [1:0] lk, input logic [8:0] bid,
                         input logic [3:0] sl, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_user = usr;
        xlat_insn_en = ien; xlat_data_en = den;
        req_key_sup = ks; req_key_user = kp; req_nx = nx; req_pp = pp;
        req_lookup = lk; req_bus_id = bid; req_seg_low = sl; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    endtask

    task automatic expect_rsp(input string tag, input logic allow,
                              input logic [1:0] flt, input logic [31:0] code,
                              input logic [2:0] perm);
        check(tag, "allow", {31'b0, rsp_allow}, {31'b0, allow});
        check(tag, "fault", {30'b0, rsp_fault}, {30'b0, flt});
        check(tag, "code", rsp_code, code);
        check(tag, "perm", {29'b0, rsp_perm}, {29'b0, perm});
    endtask

    task automatic t_reset;
        check("R1", "reset valid", {31'b0, rsp_valid}, 32'd0);
        check("R12", "reset allow", {31'b0, rsp_allow}, 32'd0);
        check("R11", "reset fault addr", rsp_fault_addr, 32'd0);
        @(negedge clk);
        check("R1", "idle valid", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_real_mode;
        // Fetch with instruction translation off, miss class ignored.
        issue(2'd2, 0, 0, 1, 0, 0, 1, 2'd0, 2'd0, 9'h0, 4'h0, 32'h1234_5000);
        expect_rsp("R2", 1, 2'd0, 32'h0, 3'b111);
        check("R2", "phys", rsp_phys_addr, 32'h1234_5000);
        check("R2", "bypass", {31'b0, rsp_bypass}, 32'd1);
        // Data read with data translation off.
        issue(2'd0, 1, 1, 0, 1, 1, 0, 2'd0, 2'd0, 9'h0, 4'h0, 32'hCAFE_0010);
        expect_rsp("R2", 1, 2'd0, 32'h0, 3'b111);
        check("R2", "phys", rsp_phys_addr, 32'hCAFE_0010);
        // Data read with only instruction translation off: not bypassed.
        issue(2'd0, 0, 0, 1, 0, 0, 0, 2'd0, 2'd0, 9'h0, 4'h0, 32'h0000_0040);
        expect_rsp("R8", 0, 2'd2, 32'h4000_0000, 3'b000);
    endtask

    task automatic t_pp_table;
        logic [2:0] exp_perm;
        for (int key = 0; key < 2; key++) begin
            for (int pp = 0; pp < 4; pp++) begin
                if (key == 0) exp_perm = (pp == 3) ? 3'b101 : 3'b111;
                else if (pp == 0) exp_perm = 3'b001;
                else if (pp == 2) exp_perm = 3'b111;
                else exp_perm = 3'b101;
                // Supervisor mode: key comes from the supervisor bit.
                issue(2'd0, 0, 1, 1, key[0], ~key[0], 0, pp[1:0], 2'd1,
                      9'h0, 4'h0, 32'h0000_1000);
                expect_rsp("R5", exp_perm[2], exp_perm[2] ? 2'd0 : 2'd2,
                           exp_perm[2] ? 32'h0 : 32'h0800_0000, exp_perm);
                check("R12", "no bypass on entry", {31'b0, rsp_bypass}, 32'd0);
            end
        end
    endtask

    task automatic t_key_select;
        // User mode takes the user key bit: key 1, PP 0, read denied.
        issue(2'd0, 1, 1, 1, 0, 1, 0, 2'd0, 2'd1, 9'h0, 4'h0, 32'h0000_2000);
        expect_rsp("R4", 0, 2'd2, 32'h0800_0000, 3'b001);
        // Supervisor mode with the same bits: key 0, read allowed.
        issue(2'd0, 0, 1, 1, 0, 1, 0, 2'd0, 2'd1, 9'h0, 4'h0, 32'h0000_2004);
        expect_rsp("R4", 1, 2'd0, 32'h0, 3'b111);
    endtask

    task automatic t_protection;
        // Write to a key-0 PP-3 page.
        issue(2'd1, 0, 1, 1, 0, 0, 0, 2'd3, 2'd1, 9'h0, 4'h0, 32'hABCD_0008);
        expect_rsp("R7", 0, 2'd2, 32'h0A00_0000, 3'b101);
        check("R11", "captured", rsp_fault_addr, 32'hABCD_0008);
        // Access kind 3 acts as a read.
        issue(2'd3, 1, 1, 1, 0, 1, 0, 2'd0, 2'd1, 9'h0, 4'h0, 32'hABCD_000C);
        expect_rsp("R12", 0, 2'd2, 32'h0800_0000, 3'b001);
    endtask

    task automatic t_noexec;
        // Fetch from a no-execute segment, also a miss: no-execute wins.
        issue(2'd2, 0, 1, 1, 0, 0, 1, 2'd2, 2'd0, 9'h0, 4'h0, 32'h0000_3000);
        expect_rsp("R6", 0, 2'd1, 32'h1000_0000, 3'b000);
        // Data read in a no-execute segment drops only the execute right.
        issue(2'd0, 0, 1, 1, 0, 0, 1, 2'd1, 2'd1, 9'h0, 4'h0, 32'h0000_3004);
        expect_rsp("R6", 1, 2'd0, 32'h0, 3'b110);
        // Key 1, PP 0 fetch still executes.
        issue(2'd2, 1, 1, 1, 0, 1, 0, 2'd0, 2'd1, 9'h0, 4'h0, 32'h0000_3008);
        expect_rsp("R6", 1, 2'd0, 32'h0, 3'b001);
        check("R11", "held after insn fault", rsp_fault_addr, 32'hABCD_000C);
    endtask

    task automatic t_miss;
        issue(2'd2, 0, 1, 1, 0, 0, 0, 2'd0, 2'd0, 9'h0, 4'h0, 32'h0000_4000);
        expect_rsp("R8", 0, 2'd1, 32'h4000_0000, 3'b000);
        check("R11", "held on insn miss", rsp_fault_addr, 32'hABCD_000C);
        issue(2'd0, 0, 1, 1, 0, 0, 0, 2'd0, 2'd3, 9'h0, 4'h0, 32'h0000_4004);
        expect_rsp("R8", 0, 2'd2, 32'h4000_0000, 3'b000);
        check("R11", "captured read miss", rsp_fault_addr, 32'h0000_4004);
        issue(2'd1, 0, 1, 1, 0, 0, 0, 2'd0, 2'd0, 9'h0, 4'h0, 32'h0000_4008);
        expect_rsp("R8", 0, 2'd2, 32'h4200_0000, 3'b000);
        check("R11", "captured write miss", rsp_fault_addr, 32'h0000_4008);
    endtask

    task automatic t_forced_io;
        issue(2'd2, 1, 1, 1, 1, 1, 1, 2'd0, 2'd2, 9'h07F, 4'hA, 32'h1234_5678);
        expect_rsp("R3", 1, 2'd0, 32'h0, 3'b111);
        check("R3", "phys", rsp_phys_addr, 32'hA234_5678);
        issue(2'd1, 1, 1, 1, 0, 0, 0, 2'd0, 2'd2, 9'h07F, 4'h3, 32'hF000_0ABC);
        expect_rsp("R3", 1, 2'd0, 32'h0, 3'b111);
        check("R3", "phys", rsp_phys_addr, 32'h3000_0ABC);
        check("R11", "held after allow", rsp_fault_addr, 32'h0000_4008);
    endtask

    task automatic t_direct_store;
        issue(2'd2, 0, 1, 1, 0, 0, 0, 2'd0, 2'd2, 9'h080, 4'h0, 32'h5000_0000);
        expect_rsp("R9", 0, 2'd1, 32'h1000_0000, 3'b000);
        issue(2'd0, 0, 1, 1, 0, 0, 0, 2'd0, 2'd2, 9'h07E, 4'h0, 32'h5000_0010);
        expect_rsp("R10", 1, 2'd0, 32'h0, 3'b100);
        check("R10", "phys", rsp_phys_addr, 32'h5000_0010);
        issue(2'd0, 0, 1, 1, 1, 0, 0, 2'd0, 2'd2, 9'h07E, 4'h0, 32'h5000_0014);
        expect_rsp("R10", 0, 2'd2, 32'h0800_0000, 3'b010);
        check("R11", "captured", rsp_fault_addr, 32'h5000_0014);
        issue(2'd1, 1, 1, 1, 0, 1, 0, 2'd0, 2'd2, 9'h07E, 4'h0, 32'h5000_0018);
        expect_rsp("R10", 1, 2'd0, 32'h0, 3'b010);
        check("R10", "bypass", {31'b0, rsp_bypass}, 32'd1);
        issue(2'd1, 0, 1, 1, 0, 1, 0, 2'd0, 2'd2, 9'h07E, 4'h0, 32'h5000_001C);
        expect_rsp("R10", 0, 2'd2, 32'h0A00_0000, 3'b100);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_user = 1'b0;
        xlat_insn_en = 1'b1; xlat_data_en = 1'b1; req_key_sup = 1'b0;
        req_key_user = 1'b0; req_nx = 1'b0; req_pp = '0; req_lookup = '0;
        req_bus_id = '0; req_seg_low = '0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_real_mode();
        t_pp_table();
        t_key_select();
        t_protection();
        t_noexec();
        t_miss();
        t_forced_io();
        t_direct_store();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule